// File: doc/BRIEF.md
# Active-Low Interrupt Status Controller

This block gathers the interrupt request lines of a backplane bus and a handful of local event conditions into a byte-wide register set for a bus bridge. It also produces one host interrupt. Each of its two status registers reports its conditions active-low, so a 0 bit means the condition is present. Each status register has a read/write enable mask beside it. A 1 in a mask bit arms the matching status bit. The host interrupt is a registered level. It is high while any armed status bit reads 0.

The seven bus request lines, the two message handshake flags, the watchdog-expired level and the power-fail and system-fail lines are all asynchronous. Each passes through a two-flop synchronizer, and the synchronizer output is the status that software reads. The bus-error indication works differently: it is a sticky flag. A strobe from the local bus interface clears the flag, and any software write to the event status register sets it again. Software reaches the four registers through a simple port: a 2-bit address, a write strobe, write data and read data that is combinational from the address.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, with all inputs inactive, the registers read as follows: offset 0 (interrupt status) 0xFF, offset 1 (interrupt mask) 0x00, offset 2 (event status) 0xDF and offset 3 (event mask) 0x08. `host_irq` is 0.
- R2: At offset 0, bit n (n = 1..7) reads the level of `bus_irq_n[n-1]`, so it reads 0 while that line is low. The value appears two clock edges after the input changes and not one edge after.
- R3: Bit 0 of offset 0 reads 0 exactly when `rsp_rd_rdy` and `rsp_wr_rdy` are both 0. Otherwise it reads 1.
- R4: At offset 2, bit 7 reads 0 while `wdog_exp` is 1, bit 2 reads `pwr_fail_n`, bit 1 is the sticky bus-error flag and bit 0 reads `sys_fail_n`. Bits 6 and 4 read 1.
- R5: In both event registers (offsets 2 and 3), bit 5 always reads 0 and bit 3 always reads 1, whatever data is written.
- R6: A write to offset 1 stores all 8 bits. A write to offset 3 stores its bits apart from the reserved ones. Both read back what was stored.
- R7: On the clock edge after any bit is 1 in a mask and 0 in its status register, `host_irq` goes to 1. It stays 1 while that holds and returns to 0 on the edge after no armed bit reads 0.
- R8: A `berr_strobe` cycle clears the bus-error flag (offset 2 bit 1) to 0 at the next edge. The flag then holds its value until software writes offset 2.
- R9: A write of any data to offset 2 sets the bus-error flag to 1. Writes to offset 0 and to the other status bits have no effect.
- R10: If `berr_strobe` and a write to offset 2 happen in the same cycle, the clear wins and the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_irq_n | input | 7 | Bus interrupt request lines, active-low; bit i is level i+1 |
| rsp_rd_rdy | input | 1 | Response register read-ready flag |
| rsp_wr_rdy | input | 1 | Response register write-ready flag |
| wdog_exp | input | 1 | Watchdog period expired, active-high level |
| pwr_fail_n | input | 1 | Bus power-fail line, active-low |
| sys_fail_n | input | 1 | Bus system-fail line, active-low |
| berr_strobe | input | 1 | One-cycle strobe: a local bus access ended in a bus error |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| host_irq | output | 1 | Combined host interrupt, registered level |

## Verification
Two functions can fall in the same clock cycle. One is the hardware clear of the bus-error flag by `berr_strobe`. The other is the software set of the same flag by a write to offset 2. The bench drives both in a single cycle and then reads offset 2, expecting bit 1 to be 0. It also checks that an armed event mask keeps `host_irq` high, and only a later write with no strobe present may restore the flag. The random phase mixes strobe-only and write-only cycles with random masks and inputs, and compares the readback against bench models of the status encoding.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] OFS_ISTATE = 2'd0;
  localparam logic [1:0] OFS_IEN    = 2'd1;
  localparam logic [1:0] OFS_ESTATE = 2'd2;
  localparam logic [1:0] OFS_EEN    = 2'd3;

  localparam int EV_WDOG = 7;
  localparam int EV_PWR  = 2;
  localparam int EV_BERR = 1;
  localparam int EV_SYS  = 0;
  localparam int RSV_ZERO = 5;
  localparam int RSV_ONE  = 3;

  // Forces the reserved event-group bits to their fixed values.
  function automatic logic [DATA_W-1:0] fix_reserved(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    r[RSV_ZERO] = 1'b0;
    r[RSV_ONE]  = 1'b1;
    return r;
  endfunction

  // Builds the active-low event status byte; unused bits read 1.
  function automatic logic [DATA_W-1:0] pack_event(input logic wdog_n, input logic pwr_n,
                                                   input logic berr_n, input logic sys_n);
    logic [DATA_W-1:0] r;
    r = '1;
    r[EV_WDOG] = wdog_n;
    r[EV_PWR]  = pwr_n;
    r[EV_BERR] = berr_n;
    r[EV_SYS]  = sys_n;
    return fix_reserved(r);
  endfunction

  // Message bit is low only when both handshake flags are low.
  function automatic logic msg_bit(input logic rd_rdy, input logic wr_rdy);
    return rd_rdy | wr_rdy;
  endfunction

  // True when some enabled bit shows an active (0) condition.
  function automatic logic any_armed(input logic [DATA_W-1:0] state,
                                     input logic [DATA_W-1:0] en);
    return |(en & ~state);
  endfunction
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH = 12,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/berr_sticky.sv
module berr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_clr,
  input  logic sw_set,
  output logic flag_n
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b1;
    else if (hw_clr) flag_q <= 1'b0;
    else if (sw_set) flag_q <= 1'b1;
  end

  assign flag_n = flag_q;

  assert_berr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !flag_n);
  assert_berr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_clr && !sw_set) |=> $stable(flag_n));
  assert_berr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !hw_clr) |=> flag_n);
  assert_berr_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && hw_clr) |=> !flag_n);
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] istate,
  input  logic [DATA_W-1:0] ien,
  input  logic [DATA_W-1:0] estate,
  input  logic [DATA_W-1:0] een,
  output logic              irq
);
  logic armed_int, armed_evt, armed_any, irq_q;

  assign armed_int = any_armed(istate, ien);
  assign armed_evt = any_armed(estate, een);
  assign armed_any = armed_int | armed_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= armed_any;
  end

  assign irq = irq_q;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_any |=> irq);
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_any |=> !irq);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int NUM_LVL = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] bus_irq_n,
  input  logic               rsp_rd_rdy,
  input  logic               rsp_wr_rdy,
  input  logic               wdog_exp,
  input  logic               pwr_fail_n,
  input  logic               sys_fail_n,
  input  logic               berr_strobe,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               host_irq
);
  localparam int SYNC_W = NUM_LVL + 5;

  logic [SYNC_W-1:0] sync_in, sync_out;
  logic [NUM_LVL-1:0] lvl_s;
  logic rd_s, wr_s, wdog_n_s, pwr_s, sys_s;
  logic berr_n;
  logic [DATA_W-1:0] istate, estate, ien_q, een_q;
  logic wr_ien, wr_een, wr_estate;

  assign sync_in = {bus_irq_n, rsp_rd_rdy, rsp_wr_rdy, ~wdog_exp, pwr_fail_n, sys_fail_n};

  irq_sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .dout(sync_out)
  );

  assign {lvl_s, rd_s, wr_s, wdog_n_s, pwr_s, sys_s} = sync_out;

  assign wr_ien    = reg_wr && (reg_addr == OFS_IEN);
  assign wr_een    = reg_wr && (reg_addr == OFS_EEN);
  assign wr_estate = reg_wr && (reg_addr == OFS_ESTATE);

  berr_sticky u_berr (
    .clk(clk), .rst_n(rst_n), .hw_clr(berr_strobe), .sw_set(wr_estate), .flag_n(berr_n)
  );

  assign istate = {lvl_s, msg_bit(rd_s, wr_s)};
  assign estate = pack_event(wdog_n_s, pwr_s, berr_n, sys_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      een_q <= fix_reserved('0);
    end else begin
      if (wr_ien) ien_q <= reg_wdata;
      if (wr_een) een_q <= fix_reserved(reg_wdata);
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ISTATE: reg_rdata = istate;
      OFS_IEN:    reg_rdata = ien_q;
      OFS_ESTATE: reg_rdata = estate;
      default:    reg_rdata = een_q;
    endcase
  end

  irq_combine u_comb (
    .clk(clk), .rst_n(rst_n), .istate(istate), .ien(ien_q),
    .estate(estate), .een(een_q), .irq(host_irq)
  );

  assert_ien_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (ien_q == $past(reg_wdata)));
  assert_ien_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ien |=> $stable(ien_q));
endmodule

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  logic clk = 0, rst_n = 0;
  logic [6:0] bus_irq_n = '1;
  logic rsp_rd_rdy = 1, rsp_wr_rdy = 1, wdog_exp = 0, pwr_fail_n = 1, sys_fail_n = 1;
  logic berr_strobe = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic host_irq;

  int checks = 0, errors = 0;
  logic m_berr = 1;
  logic [7:0] m_ien = 0, m_een = 8'h08;

  always #5 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_irq_n(bus_irq_n), .rsp_rd_rdy(rsp_rd_rdy),
    .rsp_wr_rdy(rsp_wr_rdy), .wdog_exp(wdog_exp), .pwr_fail_n(pwr_fail_n),
    .sys_fail_n(sys_fail_n), .berr_strobe(berr_strobe), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  function automatic logic [7:0] exp_int();
    return {bus_irq_n, ~(~rsp_rd_rdy & ~rsp_wr_rdy)};
  endfunction

  function automatic logic [7:0] exp_evt();
    return {~wdog_exp, 1'b1, 1'b0, 1'b1, 1'b1, pwr_fail_n, m_berr, sys_fail_n};
  endfunction

  function automatic logic exp_irq();
    logic a;
    a = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (m_ien[i] && !exp_int()[i]) a = 1'b1;
      if (m_een[i] && !exp_evt()[i]) a = 1'b1;
    end
    return a;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    if (a == 2'd1) m_ien = d;
    if (a == 2'd3) m_een = (d & 8'hDF) | 8'h08;
    if (a == 2'd2) m_berr = 1;
  endtask

  task automatic strobe(input logic with_write);
    @(negedge clk);
    berr_strobe = 1;
    if (with_write) begin reg_addr = 2'd2; reg_wdata = 8'h5A; reg_wr = 1; end
    @(negedge clk);
    berr_strobe = 0; reg_wr = 0;
    m_berr = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(2'd0, d); check({tag, " istate"}, d, exp_int());
    rd(2'd2, d); check({tag, " estate"}, d, exp_evt());
    check({tag, " host_irq"}, {7'd0, host_irq}, {7'd0, exp_irq()});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 istate", d, 8'hFF);
    rd(2'd1, d); check("R1 ien", d, 8'h00);
    rd(2'd2, d); check("R1 estate", d, 8'hDF);
    rd(2'd3, d); check("R1 een", d, 8'h08);
    check("R1 host_irq", {7'd0, host_irq}, 8'h00);

    // R9 write to interrupt status ignored
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R9 istate write ignored", d, 8'hFF);

    // R5 R6 mask readback
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R6 ien", d, 8'hA5);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R5 een all ones", d, 8'hDF);
    wr(2'd3, 8'h00); rd(2'd3, d); check("R5 een zero", d, 8'h08);
    wr(2'd2, 8'h00); rd(2'd2, d); check("R5 estate reserved", d, 8'hDF);
    wr(2'd1, 8'h00);

    // R2 synchronizer latency: level 3 line
    @(negedge clk);
    bus_irq_n[2] = 0;
    @(negedge clk);
    rd(2'd0, d); check("R2 one edge unchanged", d, 8'hFF);
    @(negedge clk);
    rd(2'd0, d); check("R2 two edges level3", d, 8'hF7);
    bus_irq_n[2] = 1;
    settle();

    // R3 message bit and R7 masking
    rsp_rd_rdy = 0; rsp_wr_rdy = 0;
    settle(); rd(2'd0, d); check("R3 both flags low", d, 8'hFE);
    wr(2'd1, 8'h01); settle(); check("R7 msg armed", {7'd0, host_irq}, 8'h01);
    rsp_wr_rdy = 1;
    settle(); rd(2'd0, d); check("R3 one flag high", d, 8'hFF);
    check("R7 cause gone", {7'd0, host_irq}, 8'h00);
    rsp_rd_rdy = 1; wr(2'd1, 8'h00);

    // R4 event map
    wdog_exp = 1; pwr_fail_n = 0; sys_fail_n = 0;
    settle(); rd(2'd2, d); check("R4 event bits", d, 8'h5A);
    wdog_exp = 0; pwr_fail_n = 1; sys_fail_n = 1;
    settle();

    // R8 sticky clear, hold, R7 irq from event group, R9 restore
    wr(2'd3, 8'h02);
    strobe(0);
    rd(2'd2, d); check("R8 cleared", d, 8'hDD);
    repeat (5) @(negedge clk);
    rd(2'd2, d); check("R8 held", d, 8'hDD);
    check("R7 event armed", {7'd0, host_irq}, 8'h01);
    wr(2'd2, 8'h77);
    rd(2'd2, d); check("R9 write restores", d, 8'hDF);
    @(negedge clk);
    check("R7 released", {7'd0, host_irq}, 8'h00);

    // R10 collision: clear wins
    strobe(1);
    rd(2'd2, d); check("R10 collision", d, 8'hDD);
    @(negedge clk);
    check("R10 irq stays", {7'd0, host_irq}, 8'h01);
    wr(2'd2, 8'h00);

    // Random phase
    for (int it = 0; it < 80; it++) begin
      int op;
      bus_irq_n  = 7'($urandom);
      rsp_rd_rdy = 1'($urandom); rsp_wr_rdy = 1'($urandom);
      wdog_exp   = 1'($urandom); pwr_fail_n = 1'($urandom); sys_fail_n = 1'($urandom);
      wr(2'd1, 8'($urandom));
      wr(2'd3, 8'($urandom));
      op = int'($urandom % 4);
      if (op == 0) strobe(0);
      else if (op == 1) wr(2'd2, 8'($urandom));
      else if (op == 2) strobe(1);
      settle();
      check_all("R2 R4 R7 R8 random");
      rd(2'd1, d); check("R6 random ien", d, m_ien);
      rd(2'd3, d); check("R5 random een", d, m_een);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule